// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Controller

This block is the interrupt and status unit that sits beside the calendar counters of a real-time clock. It holds six alarm compare bytes, one for each of seconds, minutes, hours, day of month, month and day of week. Each byte has its own compare enable. The block raises an alarm status bit when every enabled byte matches the live counters. It also captures six periodic rollover events into individual flags and keeps a main status byte. That byte combines write-one-to-clear event bits, a power-fail bit that follows the supply monitor, and a read-only interrupt-pending summary.

The enabled sources drive an active-low open-drain interrupt pin, modelled here as an active-high output enable, and a multi-function output. The multi-function output carries either the power-fail interrupt or a buffered oscillator. A mode bit chooses what happens on entry to standby: when it is clear, standby entry wipes the periodic, alarm and power-fail enables. Software reaches all of this through a small register window with two pages. The main status byte appears at the same address on both pages.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The compare byte at address 0x10+i is tested against live byte i only when compare enable bit i (page 1, address 0x04, bits 0..5) is set; a disabled byte counts as equal. The alarm status (main status bit 3) sets on the hundredth tick in which the all-bytes match begins, that is, when the previous tick did not match. Out of reset the match is treated as already present, so a tick with every enable clear sets nothing.
- R2: The alarm status sets whether or not the alarm interrupt enable (page 1, 0x04, bit 6) is set, and it asserts `intr_oe` only while that enable is 1.
- R3: Main status bits 2 (periodic summary) and 3 (alarm) clear when a 1 is written to them. Writing 0 leaves them unchanged, and a new event in the same cycle as the clear wins.
- R4: Rollover pulse `roll[i]` sets periodic flag i, read as bit i of page 0 address 0x03. Any read or write of that address clears all flags, and a rollover in the same cycle wins.
- R5: The periodic enables (page 1, 0x03, bits 0..5) gate only the summary bit 2, which then drives `intr_oe`. A summary bit already set stays set and keeps `intr_oe` asserted after the enables are turned off, until it is written clear.
- R6: Main status bit 1 follows `pwr_fail` and cannot be written; the power-fail interrupt is `pwr_fail` gated by enable bit 7 of page 1, 0x04.
- R7: Main status bit 0 is read-only and is 1 exactly while `intr_oe` is asserted or the multi-function output carries an active power-fail interrupt.
- R8: With the output select (page 1, 0x02, bit 0) at 0, `mfo` carries the power-fail interrupt (active high). At 1, `mfo` follows `osc_clk` and the power-fail interrupt moves onto `intr_oe`.
- R9: An `standby_enter` pulse while the backup-interrupt bit (page 1, 0x01, bit 0) is 0 clears the six periodic enables, the alarm enable and the power-fail enable. The compare enables are untouched. With the bit at 1 the pulse has no effect.
- R10: Main status bit 6 selects the page and bits 4, 5 and 7 are scratch storage. Address 0x00 returns the main status on both pages, and page-specific addresses read 0 on the other page.
- R11: The six compare bytes at 0x10..0x15 are read/write on both pages.
- R12: After reset every register is 0, page 0 is selected, and `intr_oe` and `mfo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe for the current address (one cycle) |
| wr_en | input | 1 | Write strobe (one cycle) |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| live_time | input | NCMP*8 | Live counter bytes, byte i at bits 8i+7..8i |
| tick_hund | input | 1 | One-cycle pulse per hundredth-second step |
| roll | input | NPER | One-cycle rollover pulses of the six periodic rates |
| pwr_fail | input | 1 | Debounced power-fail level |
| standby_enter | input | 1 | One-cycle pulse on entry to standby |
| osc_clk | input | 1 | Buffered oscillator to route to `mfo` |
| intr_oe | output | 1 | Pull-down enable of the open-drain interrupt pin |
| mfo | output | 1 | Multi-function output |

## Verification
The bench builds the block with its default parameters: six compare bytes and six periodic rates. At that size each enable field fills the low six bits of its register, so every enable pattern can be written in one access and every compare byte can be forced to match or miss on its own. The table walk covers the match-onset rule against mixed enable and mismatch masks, including the case where nothing is enabled and so no onset ever occurs. The directed part covers the clear-race, page and standby cases.

// File: rtl/rtc_irq_pkg.sv
// Package: shared widths, register addresses and bit positions of the
// alarm/interrupt controller. Assumes a byte-wide register window.
package rtc_irq_pkg;
    localparam int DW = 8;
    localparam int AW = 5;

    localparam logic [AW-1:0] A_MAIN = 5'h00;  // both pages
    localparam logic [AW-1:0] A_MODE = 5'h01;  // page 1
    localparam logic [AW-1:0] A_OUT  = 5'h02;  // page 1
    localparam logic [AW-1:0] A_PER  = 5'h03;  // page 0 flags / page 1 enables
    localparam logic [AW-1:0] A_ICTL = 5'h04;  // page 1
    localparam logic [AW-1:0] A_CMP0 = 5'h10;  // compare bytes, both pages

    localparam int MS_PEND = 0;
    localparam int MS_PF   = 1;
    localparam int MS_PER  = 2;
    localparam int MS_ALM  = 3;
    localparam int MS_PAGE = 6;
    localparam int IC_ALM  = 6;
    localparam int IC_PF   = 7;
endpackage

// File: rtl/rtc_alarm_match.sv
// Alarm compare: tests each enabled compare byte against its live counter
// byte once per hundredth tick and pulses set_pulse on the tick in which
// the overall match begins. Assumes live bytes are stable around a tick.
module rtc_alarm_match #(
    parameter int NCMP = 6,
    parameter int DW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NCMP*DW-1:0]   live,
    input  logic [NCMP*DW-1:0]   cmp_val,
    input  logic [NCMP-1:0]      cmp_en,
    output logic                 set_pulse
);
    logic [NCMP-1:0] byte_eq;
    logic            match_now;
    logic            match_prev;

    // One equality comparator per compare byte.
    for (genvar i = 0; i < NCMP; i++) begin : g_eq
        assign byte_eq[i] = (live[i*DW +: DW] == cmp_val[i*DW +: DW]);
    end

    // A disabled byte forces its comparator to read as equal.
    assign match_now = &(byte_eq | ~cmp_en);

    // Remember the match state seen at the last tick; reset counts as matched.
    always_ff @(posedge clk) begin
        if (!rst_n)    match_prev <= 1'b1;
        else if (tick) match_prev <= match_now;
    end

    assign set_pulse = tick & match_now & ~match_prev;

    // R1: an alarm event only ever arises on a hundredth tick.
    assert_alarm_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |-> tick);
endmodule

// File: rtl/rtc_period_flags.sv
// Periodic flags: one sticky flag per rollover rate, all cleared by an
// access to the flag register; also reports whether any enabled rate
// rolled over this cycle. Assumes roll pulses last one cycle.
module rtc_period_flags #(
    parameter int NPER = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPER-1:0] roll,
    input  logic [NPER-1:0] per_en,
    input  logic            clr,
    output logic [NPER-1:0] flags,
    output logic            sum_hit
);
    // Set on rollover, wipe on access; a same-cycle rollover survives.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= roll | (clr ? '0 : flags);
    end

    // Enables only steer the summary, never the individual flags.
    assign sum_hit = |(roll & per_en);

    // R4: a flag may only rise when its own rollover pulse was present.
    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(roll)) == '0));
    // R4: an access with no rollover leaves every flag clear.
    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && roll == '0) |=> (flags == '0));
endmodule

// File: rtl/rtc_irq_route.sv
// Output routing: combines the masked status sources onto the interrupt
// pin enable and the multi-function output. Purely combinational.
module rtc_irq_route (
    input  logic alarm_stat,
    input  logic alarm_ie,
    input  logic per_sum,
    input  logic pf_stat,
    input  logic pf_ie,
    input  logic mfo_sel,
    input  logic osc_clk,
    output logic intr_oe,
    output logic mfo,
    output logic irq_pend
);
    logic pf_irq;
    logic mfo_irq;

    // Power-fail interrupt exists only while the failure lasts and is enabled.
    assign pf_irq  = pf_stat & pf_ie;
    assign mfo_irq = pf_irq & ~mfo_sel;

    // Interrupt pin: masked alarm, periodic summary, and relocated power fail.
    assign intr_oe = (alarm_stat & alarm_ie) | per_sum | (pf_irq & mfo_sel);

    // Multi-function pin: power-fail interrupt or the buffered oscillator.
    assign mfo = mfo_sel ? osc_clk : pf_irq;

    // Pending summary mirrors whatever interrupt is visible on either pin.
    assign irq_pend = intr_oe | mfo_irq;

    // R7: the pending summary is never low while the interrupt pin is pulled.
    always_comb begin
        assert_pend_covers_R7: assert (irq_pend || !intr_oe);
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
// Top: register window, main status byte, enable registers and the
// standby hook of the RTC alarm/interrupt controller. Assumes the counter
// block supplies live bytes, tick and rollover pulses in this clock domain
// and that pwr_fail is already debounced.
module rtc_alarm_irq
    import rtc_irq_pkg::*;
#(
    parameter int NCMP = 6,
    parameter int NPER = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [NCMP*DW-1:0]   live_time,
    input  logic                 tick_hund,
    input  logic [NPER-1:0]      roll,
    input  logic                 pwr_fail,
    input  logic                 standby_enter,
    input  logic                 osc_clk,
    output logic                 intr_oe,
    output logic                 mfo
);
    localparam int CMP_LAST = NCMP - 1;

    logic                page_q;
    logic [2:0]          scratch_q;
    logic                alarm_q;
    logic                persum_q;
    logic                ibk_q;
    logic                mfo_sel_q;
    logic [NPER-1:0]     per_en_q;
    logic [NCMP-1:0]     cmp_en_q;
    logic                alarm_ie_q;
    logic                pf_ie_q;
    logic [DW-1:0]       cmp_q [NCMP];
    logic [NCMP*DW-1:0]  cmp_flat;

    logic wr_main, wr_mode, wr_out, wr_pen, wr_ictl, flag_acc;
    logic alarm_set, per_hit, irq_pend, wipe;
    logic [NPER-1:0] flags;

    // Address decode; page-specific registers need the matching page.
    assign wr_main  = wr_en && (addr == A_MAIN);
    assign wr_mode  = wr_en &&  page_q && (addr == A_MODE);
    assign wr_out   = wr_en &&  page_q && (addr == A_OUT);
    assign wr_pen   = wr_en &&  page_q && (addr == A_PER);
    assign wr_ictl  = wr_en &&  page_q && (addr == A_ICTL);
    assign flag_acc = (rd_en || wr_en) && !page_q && (addr == A_PER);
    assign wipe     = standby_enter && !ibk_q;

    // Compare byte storage, one register per byte.
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)                                     cmp_q[i] <= '0;
            else if (wr_en && addr == A_CMP0 + AW'(i))      cmp_q[i] <= wdata;
        end
        assign cmp_flat[i*DW +: DW] = cmp_q[i];
    end

    rtc_alarm_match #(.NCMP(NCMP), .DW(DW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_hund),
        .live      (live_time),
        .cmp_val   (cmp_flat),
        .cmp_en    (cmp_en_q),
        .set_pulse (alarm_set)
    );

    rtc_period_flags #(.NPER(NPER)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .roll    (roll),
        .per_en  (per_en_q),
        .clr     (flag_acc),
        .flags   (flags),
        .sum_hit (per_hit)
    );

    rtc_irq_route u_route (
        .alarm_stat (alarm_q),
        .alarm_ie   (alarm_ie_q),
        .per_sum    (persum_q),
        .pf_stat    (pwr_fail),
        .pf_ie      (pf_ie_q),
        .mfo_sel    (mfo_sel_q),
        .osc_clk    (osc_clk),
        .intr_oe    (intr_oe),
        .mfo        (mfo),
        .irq_pend   (irq_pend)
    );

    // Main status: page and scratch storage, event bits with write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= 1'b0;
            scratch_q <= '0;
            alarm_q   <= 1'b0;
            persum_q  <= 1'b0;
        end else begin
            if (wr_main) begin
                page_q    <= wdata[MS_PAGE];
                scratch_q <= {wdata[7], wdata[5:4]};
            end
            alarm_q  <= alarm_set | (alarm_q  & ~(wr_main & wdata[MS_ALM]));
            persum_q <= per_hit   | (persum_q & ~(wr_main & wdata[MS_PER]));
        end
    end

    // Mode and output-select registers on page 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibk_q     <= 1'b0;
            mfo_sel_q <= 1'b0;
        end else begin
            if (wr_mode) ibk_q     <= wdata[0];
            if (wr_out)  mfo_sel_q <= wdata[0];
        end
    end

    // Interrupt enables; a standby wipe takes priority over a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_en_q   <= '0;
            cmp_en_q   <= '0;
            alarm_ie_q <= 1'b0;
            pf_ie_q    <= 1'b0;
        end else begin
            if (wr_pen) per_en_q <= wdata[NPER-1:0];
            if (wr_ictl) begin
                cmp_en_q   <= wdata[NCMP-1:0];
                alarm_ie_q <= wdata[IC_ALM];
                pf_ie_q    <= wdata[IC_PF];
            end
            if (wipe) begin
                per_en_q   <= '0;
                alarm_ie_q <= 1'b0;
                pf_ie_q    <= 1'b0;
            end
        end
    end

    // Read multiplexer over the register window.
    always_comb begin
        rdata = '0;
        if (addr == A_MAIN) begin
            rdata = {scratch_q[2], page_q, scratch_q[1:0],
                     alarm_q, persum_q, pwr_fail, irq_pend};
        end else if (!page_q && addr == A_PER) begin
            rdata[NPER-1:0] = flags;
        end else if (page_q && addr == A_MODE) begin
            rdata[0] = ibk_q;
        end else if (page_q && addr == A_OUT) begin
            rdata[0] = mfo_sel_q;
        end else if (page_q && addr == A_PER) begin
            rdata[NPER-1:0] = per_en_q;
        end else if (page_q && addr == A_ICTL) begin
            rdata[NCMP-1:0] = cmp_en_q;
            rdata[IC_ALM]   = alarm_ie_q;
            rdata[IC_PF]    = pf_ie_q;
        end else begin
            for (int i = 0; i <= CMP_LAST; i++) begin
                if (addr == A_CMP0 + AW'(i)) rdata = cmp_q[i];
            end
        end
    end

    // R3: writing 1 to the alarm bit clears it unless a new alarm arrives.
    assert_alarm_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_main && wdata[MS_ALM] && !alarm_set) |=> !alarm_q);
    // R5: the periodic summary can only drop through a write-one clear.
    assert_persum_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (persum_q && !(wr_main && wdata[MS_PER])) |=> persum_q);
    // R9: standby entry without backup interrupts wipes the enables.
    assert_standby_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_enter && !ibk_q) |=> (per_en_q == '0 && !alarm_ie_q && !pf_ie_q));
    // R9: standby entry never disturbs the compare enables.
    assert_cmp_en_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_enter && !wr_ictl) |=> $stable(cmp_en_q));
endmodule

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
    localparam int NCMP = 6;
    localparam int NPER = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NCMP*8-1:0] live_time = '0;
    logic tick_hund = 1'b0;
    logic [NPER-1:0] roll = '0;
    logic pwr_fail = 1'b0, standby_enter = 1'b0, osc_clk = 1'b0;
    logic intr_oe, mfo;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rtc_alarm_irq #(.NCMP(NCMP), .NPER(NPER)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_time(live_time), .tick_hund(tick_hund),
        .roll(roll), .pwr_fail(pwr_fail), .standby_enter(standby_enter),
        .osc_clk(osc_clk), .intr_oe(intr_oe), .mfo(mfo)
    );

    // {expected alarm, compare enables, mismatching bytes}
    localparam logic [12:0] VEC [8] = '{
        {1'b1, 6'h3F, 6'h00}, {1'b0, 6'h3F, 6'h01},
        {1'b1, 6'h01, 6'h3E}, {1'b1, 6'h20, 6'h1F},
        {1'b0, 6'h20, 6'h20}, {1'b0, 6'h00, 6'h3F},
        {1'b1, 6'h12, 6'h2D}, {1'b0, 6'h0C, 6'h04}
    };

    function automatic logic [7:0] cval(int i);
        return 8'(i * 3 + 1);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_hund = 1'b1;
        @(negedge clk); tick_hund = 1'b0;
    endtask

    task automatic pulse_roll(input logic [NPER-1:0] r);
        @(negedge clk); roll = r;
        @(negedge clk); roll = '0;
    endtask

    task automatic set_live(input logic [5:0] mis);
        for (int i = 0; i < NCMP; i++)
            live_time[i*8 +: 8] = mis[i] ? cval(i) + 8'h40 : cval(i);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        peek(5'h00, d); check("R12 status", d, 8'h00);
        check("R12 intr_oe", {7'b0, intr_oe}, 8'h00);
        check("R12 mfo", {7'b0, mfo}, 8'h00);
        // R1: after reset, a tick with nothing enabled is not an onset
        tick(); peek(5'h00, d); check("R1 no onset after reset", d, 8'h00);

        // R11 compare bytes
        for (int i = 0; i < NCMP; i++) wr(5'h10 + 5'(i), cval(i));
        peek(5'h12, d); check("R11 compare readback", d, cval(2));

        // R1/R2 vector walk, page 1, alarm interrupt disabled
        wr(5'h00, 8'h40);
        for (int k = 0; k < 8; k++) begin
            wr(5'h04, {2'b00, VEC[k][11:6]});
            set_live(6'h3F);
            tick();
            wr(5'h00, 8'h48);
            set_live(VEC[k][5:0]);
            tick();
            peek(5'h00, d);
            check("R1 alarm onset", {7'b0, d[3]}, {7'b0, VEC[k][12]});
            check("R2 no pin without enable", {7'b0, intr_oe}, 8'h00);
        end

        // R2 with alarm interrupt enabled
        wr(5'h04, 8'h7F);
        set_live(6'h00);
        tick();
        check("R2 pin with enable", {7'b0, intr_oe}, 8'h01);
        peek(5'h00, d); check("R7 pending set", {7'b0, d[0]}, 8'h01);
        // R3 writing zero does not clear, writing one does
        wr(5'h00, 8'h40); peek(5'h00, d); check("R3 zero keeps", {7'b0, d[3]}, 8'h01);
        wr(5'h00, 8'h48); peek(5'h00, d); check("R3 one clears", {7'b0, d[3]}, 8'h00);
        check("R3 pin released", {7'b0, intr_oe}, 8'h00);
        wr(5'h04, 8'h00);

        // R4 periodic flags on page 0
        wr(5'h00, 8'h00);
        pulse_roll(6'b000101);
        peek(5'h03, d); check("R4 flags set", d, 8'h05);
        rd(5'h03, d);   check("R4 read value", d, 8'h05);
        peek(5'h03, d); check("R4 cleared by read", d, 8'h00);
        pulse_roll(6'b100000);
        wr(5'h03, 8'h00);
        peek(5'h03, d); check("R4 cleared by write", d, 8'h00);
        peek(5'h00, d); check("R5 no summary unenabled", d, 8'h00);

        // R5 summary gating and persistence
        wr(5'h00, 8'h40);
        wr(5'h03, 8'h02);
        pulse_roll(6'b000001);
        peek(5'h00, d); check("R5 other rate ignored", {7'b0, d[2]}, 8'h00);
        pulse_roll(6'b000010);
        peek(5'h00, d); check("R5 summary set", {7'b0, d[2]}, 8'h01);
        wr(5'h03, 8'h00);
        check("R5 pin holds after disable", {7'b0, intr_oe}, 8'h01);
        wr(5'h00, 8'h44);
        peek(5'h00, d); check("R5 summary cleared", {7'b0, d[2]}, 8'h00);
        check("R5 pin released", {7'b0, intr_oe}, 8'h00);

        // R6/R8 power fail routing
        @(negedge clk); pwr_fail = 1'b1;
        peek(5'h00, d); check("R6 status follows input", {7'b0, d[1]}, 8'h01);
        check("R6 masked", {6'b0, mfo, intr_oe}, 8'h00);
        wr(5'h04, 8'h80);
        check("R8 mfo carries power fail", {6'b0, mfo, intr_oe}, 8'h02);
        peek(5'h00, d); check("R7 pending from mfo", {7'b0, d[0]}, 8'h01);
        wr(5'h02, 8'h01);
        @(negedge clk); osc_clk = 1'b1; #1;
        check("R8 oscillator high", {6'b0, mfo, intr_oe}, 8'h03);
        @(negedge clk); osc_clk = 1'b0; #1;
        check("R8 oscillator low", {6'b0, mfo, intr_oe}, 8'h01);
        wr(5'h00, 8'h42);
        peek(5'h00, d); check("R6 not writable", {7'b0, d[1]}, 8'h01);
        @(negedge clk); pwr_fail = 1'b0;
        peek(5'h00, d); check("R6 self clears", {6'b0, d[1:0]}, 8'h00);
        check("R6 pin released", {7'b0, intr_oe}, 8'h00);

        // R9 standby wipe
        wr(5'h03, 8'h3F); wr(5'h04, 8'hC5);
        @(negedge clk); standby_enter = 1'b1;
        @(negedge clk); standby_enter = 1'b0;
        peek(5'h03, d); check("R9 periodic enables wiped", d, 8'h00);
        peek(5'h04, d); check("R9 irq enables wiped, compare kept", d, 8'h05);
        wr(5'h01, 8'h01);
        wr(5'h03, 8'h3F); wr(5'h04, 8'hC5);
        @(negedge clk); standby_enter = 1'b1;
        @(negedge clk); standby_enter = 1'b0;
        peek(5'h03, d); check("R9 kept with backup bit", d, 8'h3F);
        peek(5'h04, d); check("R9 irq kept with backup bit", d, 8'hC5);

        // R10 paging and scratch
        peek(5'h01, d); check("R10 page1 mode", d, 8'h01);
        wr(5'h00, 8'hB0);
        peek(5'h00, d); check("R10 scratch page0", d, 8'hB0);
        peek(5'h01, d); check("R10 page1 hidden", d, 8'h00);
        wr(5'h00, 8'hF0);
        peek(5'h00, d); check("R10 main on page1", d, 8'hF0);
        peek(5'h15, d); check("R11 compare on page1", d, cval(5));

        done = 1'b1;
        finish_run();
    end
endmodule